// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is a single DMA channel that streams data between system memory and one fixed peripheral FIFO. It holds two buffer slots (A and B), each made of a start-address register and a byte-count register. While one slot is being drained, software refills the other. A buffer-in-use flag records which slot the engine is working on. When a slot's count reaches zero, the engine marks that slot done and moves to the other slot. If the other slot is armed, the transfer carries on without a gap.

Software reaches the channel over a simple register bus. The status register has no plain write address. Software changes it only through a set alias and a clear alias, and reads it at a third offset. One device register packs the whole peripheral configuration into a single word: direction, endianness, burst size, data width, peripheral select and peripheral address. Data moves in bursts over a request/acknowledge memory port. Each burst is gated by the peripheral's request line and answered with a one-cycle peripheral acknowledge. An interrupt line reports completed buffers and errors.

Top module: `dbdma_chan`

## Requirements
- R1: The status register is written through offset 0x04, where each 1 bit sets the matching status bit, and through offset 0x08, where each 1 bit clears it. Zero bits in either write have no effect. Offset 0x0C reads the status. The bit positions are: 0 run, 1 interrupt enable, 2 error, 3 done A, 4 start A, 5 done B, 6 start B, 7 buffer in use (0 = A, 1 = B). Bit 7 is changed only by the engine, never by either alias. All status bits are 0 after reset.
- R2: The device register sits at offset 0x00 and is decoded as follows:
  - bit 0 is the direction, where 1 means peripheral to memory; it drives `mem_wr`.
  - bit 1 selects big-endian order (`mem_big_endian`).
  - bit 2 sets the burst length, 0 for 4 units and 1 for 8 units.
  - bit 3 sets the data width, 0 for 8-bit and 1 for 16-bit (`mem_wide`).
  - bits 7:4 are the peripheral select (`per_sel`).
  - `per_addr` is built from register bits 31:28 as address bits 31:28 and register bits 27:8 as address bits 21:2; all other address bits are 0.
- R3: A write to the device register is ignored while run is set, and is accepted while run is clear.
- R4: Slot A's address and count are at offsets 0x10 and 0x14; slot B's are at 0x18 and 0x1C. A count keeps only its low 13 bits, so the largest count is 0x1FFF bytes.
- R5: `irq` is high exactly while interrupt enable is set and at least one of error, done A or done B is set. Writing those bits to the clear alias drops it.
- R6: Each burst carries min(remaining count, units × width bytes) bytes, at `mem_addr` equal to the in-use slot's current address. When the burst completes, that slot's address increases by the burst size and its count decreases by the same amount.
- R7: A burst starts only while run is set, the in-use slot's start bit is set and `per_req` is high. `mem_req` then stays high, with a stable address and size, until `mem_ack`. Clearing run stops new bursts but lets an in-flight burst finish, leaving the slot state intact. Setting run again resumes from the same point.
- R8: `per_ack` is a one-cycle pulse in the cycle after `mem_ack` completes a burst.
- R9: When the in-use slot's count reaches zero, three things happen in the same update: its done bit is set, its start bit is cleared, and buffer-in-use flips. Work then continues on the other slot if that slot's start bit is set.
- R10: With run set and the in-use slot started, two conditions are errors: an address whose low two bits are not 00, or a count of zero. Either one sets error and clears run, and no request is issued.
- R11: An engine event beats a software status write in the same cycle. A completing buffer's done bit ends set even if the clear alias clears it in that cycle. An error leaves run clear even if the set alias sets it in that cycle.
- R12: A read strobe with an offset returns the register value on `reg_rdata` one cycle later. Offsets 0x04, 0x08 and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Memory burst request, held until acknowledged |
| mem_addr | output | 32 | Burst start address |
| mem_bytes | output | 5 | Burst length in bytes |
| mem_wr | output | 1 | 1 = write to memory (peripheral to memory) |
| mem_wide | output | 1 | 1 = 16-bit units, 0 = 8-bit units |
| mem_big_endian | output | 1 | Byte order of the transfer |
| mem_ack | input | 1 | Burst completion from memory |
| per_req | input | 1 | Peripheral ready for a burst |
| per_ack | output | 1 | One-cycle pulse per completed burst |
| per_sel | output | 4 | Peripheral select |
| per_addr | output | 32 | Peripheral FIFO address |

## Verification
The delicate case is a software status write that lands in the same cycle as an engine event. The first pairing is a buffer completion (done set, start cleared, buffer-in-use flipped) against a write to the clear alias that tries to remove that done bit. The second pairing is error detection against a write to the set alias that tries to raise run. Each pairing is provoked with a zero-latency memory responder and a write placed on the exact edge where the burst acknowledge, or the misaligned start, is sampled. The outcome is judged by reading the status word back and comparing every output against a behavioural model on every clock.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  // status word geometry
  localparam int STAT_W   = 8;
  localparam int ST_RUN   = 0;
  localparam int ST_IE    = 1;
  localparam int ST_ERR   = 2;
  localparam int ST_DONEA = 3;
  localparam int ST_STRTA = 4;
  localparam int ST_DONEB = 5;
  localparam int ST_STRTB = 6;
  localparam int ST_BIU   = 7;
  // bits software may touch through the set/clear aliases
  localparam logic [STAT_W-1:0] SW_MASK = 8'h7F;

  // device word fields
  localparam int DV_DIR   = 0;
  localparam int DV_BE    = 1;
  localparam int DV_BURST = 2;
  localparam int DV_WIDE  = 3;
  localparam int DV_SEL_LO = 4;

  // register offsets
  localparam int OFS_DEV  = 0;
  localparam int OFS_SSET = 4;
  localparam int OFS_SCLR = 8;
  localparam int OFS_SRD  = 12;
  localparam int OFS_SLOT0 = 16;
  localparam int SLOT_STRIDE = 8;
endpackage

// File: rtl/dbdma_slot.sv
module dbdma_slot
  import dbdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 13,
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter int BURST_W = 5,
  parameter int SLOT    = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [REG_AW-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               adv,
  input  logic [BURST_W-1:0] adv_bytes,
  output logic [ADDR_W-1:0]  cur_addr,
  output logic [CNT_W-1:0]   cur_cnt
);
  localparam int OFS_ADDR = OFS_SLOT0 + SLOT_STRIDE * SLOT;
  localparam int OFS_CNT  = OFS_ADDR + 4;

  // engine advance has priority over a same-cycle software write
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else if (adv) begin
      cur_addr <= cur_addr + ADDR_W'(adv_bytes);
      cur_cnt  <= cur_cnt - CNT_W'(adv_bytes);
    end else if (wr_en) begin
      if (wr_addr == REG_AW'(OFS_ADDR)) cur_addr <= wr_data[ADDR_W-1:0];
      if (wr_addr == REG_AW'(OFS_CNT))  cur_cnt  <= wr_data[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/dbdma_status.sv
module dbdma_status
  import dbdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [STAT_W-1:0] wmask,
  input  logic              err_evt,
  input  logic              fin_evt,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq
);
  logic [STAT_W-1:0] stat_d;

  // software first, then engine events on top so they win
  always_comb begin
    stat_d = stat_q;
    if (set_we) stat_d = stat_d | (wmask & SW_MASK);
    if (clr_we) stat_d = stat_d & ~(wmask & SW_MASK);
    if (err_evt) begin
      stat_d[ST_ERR] = 1'b1;
      stat_d[ST_RUN] = 1'b0;
    end
    if (fin_evt) begin
      if (stat_q[ST_BIU]) begin
        stat_d[ST_DONEB] = 1'b1;
        stat_d[ST_STRTB] = 1'b0;
      end else begin
        stat_d[ST_DONEA] = 1'b1;
        stat_d[ST_STRTA] = 1'b0;
      end
      stat_d[ST_BIU] = ~stat_q[ST_BIU];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq    <= stat_d[ST_IE] & (stat_d[ST_ERR] | stat_d[ST_DONEA] | stat_d[ST_DONEB]);
    end
  end
endmodule

// File: rtl/dbdma_burst.sv
module dbdma_burst #(
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 13,
  parameter int BURST_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic [ADDR_W-1:0]  cur_addr,
  input  logic [CNT_W-1:0]   cur_cnt,
  input  logic [BURST_W-1:0] burst_bytes,
  input  logic               per_req,
  input  logic               mem_ack,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BURST_W-1:0] mem_bytes,
  output logic               per_ack,
  output logic               err_evt,
  output logic               adv_evt,
  output logic               fin_evt
);
  logic               bad;
  logic               launch;
  logic [BURST_W-1:0] take;

  assign bad     = (cur_addr[1:0] != 2'b00) || (cur_cnt == '0);
  assign take    = (cur_cnt < CNT_W'(burst_bytes)) ? cur_cnt[BURST_W-1:0] : burst_bytes;
  assign err_evt = !mem_req && go && bad;
  assign launch  = !mem_req && go && !bad && per_req;
  assign adv_evt = mem_req && mem_ack;
  assign fin_evt = adv_evt && (cur_cnt == CNT_W'(mem_bytes));

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_bytes <= '0;
      per_ack   <= 1'b0;
    end else begin
      per_ack <= adv_evt;
      if (launch) begin
        mem_req   <= 1'b1;
        mem_addr  <= cur_addr;
        mem_bytes <= take;
      end else if (adv_evt) begin
        mem_req <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
  import dbdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 13,
  parameter int REG_AW  = 5,
  parameter int BURST_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq,
  output logic               mem_req,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [BURST_W-1:0] mem_bytes,
  output logic               mem_wr,
  output logic               mem_wide,
  output logic               mem_big_endian,
  input  logic               mem_ack,
  input  logic               per_req,
  output logic               per_ack,
  output logic [3:0]         per_sel,
  output logic [ADDR_W-1:0]  per_addr
);
  localparam int NSLOT = 2;

  logic [STAT_W-1:0]  stat_q;
  logic [DATA_W-1:0]  dev_q;
  logic [ADDR_W-1:0]  slot_addr [NSLOT];
  logic [CNT_W-1:0]   slot_cnt  [NSLOT];
  logic               biu;
  logic               go;
  logic               err_evt, adv_evt, fin_evt;
  logic [BURST_W-1:0] units, burst_bytes;
  logic [DATA_W-1:0]  rd_mux;

  assign biu = stat_q[ST_BIU];
  assign go  = stat_q[ST_RUN] && (biu ? stat_q[ST_STRTB] : stat_q[ST_STRTA]);

  dbdma_status u_status (
    .clk     (clk),
    .rst     (rst),
    .set_we  (reg_wr && reg_addr == REG_AW'(OFS_SSET)),
    .clr_we  (reg_wr && reg_addr == REG_AW'(OFS_SCLR)),
    .wmask   (reg_wdata[STAT_W-1:0]),
    .err_evt (err_evt),
    .fin_evt (fin_evt),
    .stat_q  (stat_q),
    .irq     (irq)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    dbdma_slot #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
      .REG_AW(REG_AW), .BURST_W(BURST_W), .SLOT(g)
    ) u_slot (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (reg_wr),
      .wr_addr   (reg_addr),
      .wr_data   (reg_wdata),
      .adv       (adv_evt && (biu == g[0])),
      .adv_bytes (mem_bytes),
      .cur_addr  (slot_addr[g]),
      .cur_cnt   (slot_cnt[g])
    );
  end

  // device register: locked while the channel runs
  always_ff @(posedge clk) begin
    if (rst) dev_q <= '0;
    else if (reg_wr && reg_addr == REG_AW'(OFS_DEV) && !stat_q[ST_RUN]) dev_q <= reg_wdata;
  end

  assign units       = dev_q[DV_BURST] ? BURST_W'(8) : BURST_W'(4);
  assign burst_bytes = dev_q[DV_WIDE] ? (units << 1) : units;

  dbdma_burst #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_W(BURST_W)) u_burst (
    .clk         (clk),
    .rst         (rst),
    .go          (go),
    .cur_addr    (slot_addr[biu]),
    .cur_cnt     (slot_cnt[biu]),
    .burst_bytes (burst_bytes),
    .per_req     (per_req),
    .mem_ack     (mem_ack),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_bytes   (mem_bytes),
    .per_ack     (per_ack),
    .err_evt     (err_evt),
    .adv_evt     (adv_evt),
    .fin_evt     (fin_evt)
  );

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      REG_AW'(OFS_DEV):                  rd_mux = dev_q;
      REG_AW'(OFS_SRD):                  rd_mux = DATA_W'(stat_q);
      REG_AW'(OFS_SLOT0):                rd_mux = DATA_W'(slot_addr[0]);
      REG_AW'(OFS_SLOT0 + 4):            rd_mux = DATA_W'(slot_cnt[0]);
      REG_AW'(OFS_SLOT0 + SLOT_STRIDE):     rd_mux = DATA_W'(slot_addr[1]);
      REG_AW'(OFS_SLOT0 + SLOT_STRIDE + 4): rd_mux = DATA_W'(slot_cnt[1]);
      default:                           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign mem_wr         = dev_q[DV_DIR];
  assign mem_big_endian = dev_q[DV_BE];
  assign mem_wide       = dev_q[DV_WIDE];
  assign per_sel        = dev_q[DV_SEL_LO+3:DV_SEL_LO];
  assign per_addr       = {dev_q[31:28], 6'b0, dev_q[27:8], 2'b00};
endmodule

// File: rtl/dbdma_chan_chk.sv
module dbdma_chan_chk
  import dbdma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 5,
  parameter int BURST_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_wr,
  input logic [REG_AW-1:0]  reg_addr,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [BURST_W-1:0] mem_bytes,
  input logic               per_req,
  input logic               per_ack,
  input logic [STAT_W-1:0]  stat_q,
  input logic [DATA_W-1:0]  dev_q,
  input logic               err_evt,
  input logic               fin_evt
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_bytes));

  // R7
  launch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(stat_q[ST_RUN]) && $past(per_req));

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    per_ack |-> $past(mem_req && mem_ack));

  // R3
  dev_lock_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && reg_addr == REG_AW'(OFS_DEV) && stat_q[ST_RUN] |=> $stable(dev_q));

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> stat_q[ST_ERR] && !stat_q[ST_RUN] && !mem_req);

  // R9
  fin_swap_chk: assert property (@(posedge clk) disable iff (rst)
    fin_evt |=> stat_q[ST_BIU] != $past(stat_q[ST_BIU]));

  // R6
  burst_cap_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_bytes != '0 && mem_bytes <= BURST_W'(16));
endmodule

bind dbdma_chan dbdma_chan_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .BURST_W(BURST_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
  .per_req(per_req), .per_ack(per_ack), .stat_q(stat_q), .dev_q(dev_q),
  .err_evt(err_evt), .fin_evt(fin_evt)
);

// File: tb/dbdma_chan_test.sv
`timescale 1ns/1ps
module dbdma_chan_test;
  logic        clk = 0;
  logic        rst;
  logic        reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, mem_req, mem_wr, mem_wide, mem_big_endian, mem_ack, per_req, per_ack;
  logic [31:0] mem_addr, per_addr;
  logic [4:0]  mem_bytes;
  logic [3:0]  per_sel;

  int vectors = 0, fails = 0, lat = 1, wcnt = 0;

  always #2 clk = ~clk;

  dbdma_chan uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_bytes(mem_bytes), .mem_wr(mem_wr), .mem_wide(mem_wide),
    .mem_big_endian(mem_big_endian), .mem_ack(mem_ack), .per_req(per_req),
    .per_ack(per_ack), .per_sel(per_sel), .per_addr(per_addr)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_st;
  logic [31:0] m_dev, m_rd, m_maddr;
  logic [31:0] m_a [2];
  logic [12:0] m_c [2];
  logic [4:0]  m_mb;
  logic        m_busy, m_req, m_pack, m_irq;
  int          mb, bb, cnt, take;
  bit          e_err, e_fin, e_adv;
  logic [7:0]  s;

  function automatic logic [31:0] model_read(logic [4:0] a);
    case (a)
      5'd0:  return m_dev;
      5'd12: return {24'b0, m_st};
      5'd16: return m_a[0];
      5'd20: return {19'b0, m_c[0]};
      5'd24: return m_a[1];
      5'd28: return {19'b0, m_c[1]};
      default: return 32'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_dev = 0; m_rd = 0; m_maddr = 0; m_mb = 0;
      m_busy = 0; m_req = 0; m_pack = 0; m_irq = 0;
      for (int k = 0; k < 2; k++) begin m_a[k] = 0; m_c[k] = 0; end
    end else begin
      mb = m_st[7];
      bb = (m_dev[2] ? 8 : 4) * (m_dev[3] ? 2 : 1);
      cnt = m_c[mb];
      take = (cnt < bb) ? cnt : bb;
      e_err = 0; e_fin = 0; e_adv = 0;
      if (reg_rd) m_rd = model_read(reg_addr);
      m_pack = 0;
      if (!m_busy) begin
        if (m_st[0] && (mb ? m_st[6] : m_st[4])) begin
          if (m_a[mb][1:0] != 0 || cnt == 0) e_err = 1;
          else if (per_req) begin
            m_busy = 1; m_req = 1; m_maddr = m_a[mb]; m_mb = take[4:0];
          end
        end
      end else if (mem_ack) begin
        m_busy = 0; m_req = 0; m_pack = 1; e_adv = 1;
        e_fin = (cnt == int'(m_mb));
      end
      for (int k = 0; k < 2; k++) begin
        if (e_adv && k == mb) begin
          m_a[k] = m_a[k] + 32'(m_mb);
          m_c[k] = m_c[k] - 13'(m_mb);
        end else if (reg_wr && reg_addr == 5'(16 + 8*k)) m_a[k] = reg_wdata;
        else if (reg_wr && reg_addr == 5'(20 + 8*k)) m_c[k] = reg_wdata[12:0];
      end
      if (reg_wr && reg_addr == 0 && !m_st[0]) m_dev = reg_wdata;
      s = m_st;
      if (reg_wr && reg_addr == 4) s = s | (reg_wdata[7:0] & 8'h7F);
      if (reg_wr && reg_addr == 8) s = s & ~(reg_wdata[7:0] & 8'h7F);
      if (e_err) begin s[2] = 1; s[0] = 0; end
      if (e_fin) begin
        if (mb != 0) begin s[5] = 1; s[6] = 0; end
        else begin s[3] = 1; s[4] = 0; end
        s[7] = ~m_st[7];
      end
      m_st = s;
      m_irq = s[1] & (s[2] | s[3] | s[5]);
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R7", "mem_req", {31'b0, mem_req}, {31'b0, m_req});
      if (m_req) begin
        chk("R6", "mem_addr", mem_addr, m_maddr);
        chk("R6", "mem_bytes", {27'b0, mem_bytes}, {27'b0, m_mb});
      end
      chk("R8", "per_ack", {31'b0, per_ack}, {31'b0, m_pack});
      chk("R5", "irq", {31'b0, irq}, {31'b0, m_irq});
      chk("R12", "reg_rdata", reg_rdata, m_rd);
    end
  end

  // memory responder with programmable latency
  always @(negedge clk) begin
    if (rst) begin mem_ack = 0; wcnt = 0; end
    else if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin mem_ack = 1; wcnt = 0; end
      else wcnt++;
    end else mem_ack = 0;
  end

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic wr(int a, logic [31:0] d);
    reg_wr = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_rd = 1; reg_addr = 5'(a);
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, d1, d2;
    rst = 1; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; per_req = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "mem_req after reset", {31'b0, mem_req}, 0);
    chk("R1", "irq after reset", {31'b0, irq}, 0);
    rd(12, d); chk("R1", "status after reset", d, 0);
    rd(4, d);  chk("R12", "set alias reads zero", d, 0);

    // R2 device register decode
    wr(0, 32'hA123_455F);
    rd(0, d); chk("R2", "device readback", d, 32'hA123_455F);
    chk("R2", "per_addr", per_addr, 32'hA004_8D14);
    chk("R2", "per_sel", {28'b0, per_sel}, 5);
    chk("R2", "mem_wr", {31'b0, mem_wr}, 1);
    chk("R2", "mem_wide", {31'b0, mem_wide}, 1);
    chk("R2", "mem_big_endian", {31'b0, mem_big_endian}, 1);

    // R1 set/clear aliases, bit 7 not writable
    wr(4, 32'h0000_FF82);
    rd(12, d); chk("R1", "set IE, BIU masked", d, 32'h02);
    wr(4, 32'h04);
    chk("R5", "irq on error with IE", {31'b0, irq}, 1);
    wr(8, 32'h04);
    chk("R5", "irq dropped after clear", {31'b0, irq}, 0);
    wr(8, 32'h0);
    rd(12, d); chk("R1", "zero clear has no effect", d, 32'h02);

    // R4 slot programming, 13-bit count
    wr(16, 32'h100); wr(20, 32'h3_0028); wr(24, 32'h400); wr(28, 32'h0C);
    rd(20, d); chk("R4", "count truncated to 13 bits", d, 32'h28);
    rd(24, d); chk("R4", "slot B address", d, 32'h400);

    // R6/R9 ping-pong with 16-byte bursts
    per_req = 1; lat = 1;
    wr(4, 32'h51);
    idle(3);
    wr(0, 32'h0);
    rd(0, d); chk("R3", "device write ignored while running", d, 32'hA123_455F);
    idle(40);
    rd(12, d); chk("R9", "both slots done, BIU back to A", d, 32'h2B);
    rd(16, d); chk("R6", "slot A address advanced", d, 32'h128);
    rd(20, d); chk("R6", "slot A count drained", d, 0);
    rd(24, d); chk("R6", "slot B address advanced", d, 32'h40C);
    chk("R5", "irq with done bits", {31'b0, irq}, 1);
    wr(8, 32'h28);
    chk("R5", "irq acknowledged", {31'b0, irq}, 0);

    // R7 gating and pause/resume with 4-byte bursts
    wr(8, 32'h01);
    wr(0, 32'h51);
    rd(0, d); chk("R3", "device write accepted when stopped", d, 32'h51);
    wr(16, 32'h200); wr(20, 32'h40);
    per_req = 0;
    wr(4, 32'h11);
    idle(5);
    chk("R7", "no request without per_req", {31'b0, mem_req}, 0);
    per_req = 1;
    idle(10);
    wr(8, 32'h01);
    idle(6);
    rd(16, d1);
    idle(5);
    rd(16, d2);
    chk("R7", "address frozen while paused", d2, d1);
    chk("R7", "no request while paused", {31'b0, mem_req}, 0);
    wr(4, 32'h01);
    idle(150);
    rd(16, d); chk("R6", "resumed slot A completed", d, 32'h240);
    rd(12, d); chk("R9", "slot A done, BIU now B", d, 32'h8B);

    // R10 misaligned start on slot B
    wr(8, 32'h08);
    wr(24, 32'h302); wr(28, 32'h8);
    wr(4, 32'h40);
    idle(3);
    rd(12, d); chk("R10", "misaligned start -> error, run cleared", d, 32'hC6);
    chk("R10", "no request after error", {31'b0, mem_req}, 0);
    chk("R10", "irq on error", {31'b0, irq}, 1);
    // R10 zero count
    wr(8, 32'h04);
    wr(24, 32'h300); wr(28, 32'h0);
    wr(4, 32'h01);
    idle(3);
    rd(12, d); chk("R10", "zero count -> error, run cleared", d, 32'hC6);

    // R11 completion coincides with clear of DONE_B
    wr(8, 32'h45);
    wr(24, 32'h500); wr(28, 32'h4);
    lat = 0; per_req = 1;
    wr(4, 32'h41);
    idle(1);
    wr(8, 32'h20);
    idle(2);
    rd(12, d); chk("R11", "done survives same-cycle clear", d, 32'h23);
    // R11 error coincides with set of RUN
    wr(4, 32'h10);
    wr(4, 32'h01);
    idle(2);
    rd(12, d); chk("R11", "error beats same-cycle run set", d, 32'h36);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule